// File: doc/BRIEF.md
# Complementary-Pair Output Lock

This block protects a small combinational function by routing every primary input through two keyed branches that compute a function and its exact inverse. When the two key halves agree with the polarity pattern fixed at build time, the branches always disagree. Their AND, the flip signal, then stays low and the protected output passes through unchanged. For any other key pair, exactly one input pattern drives both branches high, and the flip signal inverts one chosen output bit for that pattern only. Because each input pattern exposes at most one wrong key, an attacker who can only query inputs and outputs must try a number of patterns that grows with two to the power of the input width.

The branch function is the N-input AND. Branch A mixes each input bit with a bit of key half A. Bit positions set in the polarity pattern use XNOR, and the rest use XOR. Branch B mixes each input bit with a bit of key half B through plain XOR, then inverts the AND of the result. The example protected function, the flip gate and both output vectors sit behind one register stage with a synchronous active-low reset.

Top module: `cplock_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, fn_out and locked_out both become all zeros after that edge.
- R2: One cycle after prim_in is sampled, bit j of fn_out equals prim_in[j] XOR prim_in[(j+1) mod N].
- R3: Every locked_out bit other than index PROT_IDX always equals the same bit of fn_out, so the two vectors differ in at most one bit.
- R4: When key_a XOR key_b equals the polarity pattern POL, locked_out equals fn_out for every value of prim_in.
- R5: Branch A is all ones exactly when prim_in XOR key_a XOR POL is all ones (XNOR at positions where POL is 1). Branch B, before its inversion, is all ones exactly when prim_in XOR key_b is all ones. Bit PROT_IDX of locked_out is inverted relative to fn_out one cycle after an input for which branch A is all ones and branch B is not.
- R6: For a key pair with key_a XOR key_b not equal to POL, exactly one of the 2^N input patterns corrupts locked_out, namely prim_in equal to the bitwise inverse of (key_a XOR POL).
- R7: Distinct key pairs that share the same key_a XOR key_b equal to POL are all accepted, and none corrupts any input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prim_in | input | N | Primary inputs of the protected function |
| key_a | input | N | Key half mixed into the true branch |
| key_b | input | N | Key half mixed into the inverted branch |
| fn_out | output | N | Registered output of the unlocked example function |
| locked_out | output | N | Registered output after the flip gate on bit PROT_IDX |

## Verification
The main hazard is a lock that corrupts too much or too little. A wrong key that corrupts several patterns, or none at all, points to a broken complement or a polarity mismatch. The bench therefore sweeps all 2^N inputs for each wrong key pair, counts the corrupted patterns, and checks that the count is one and that the pattern is the one predicted. Correct pairs are swept in full too, including pairs with different individual halves, because a design that compares the halves directly instead of using their XOR would reject them. The bench also checks that bits other than the protected index never move, which catches a flip routed to the wrong bit.

// File: rtl/cplock_pkg.sv
// Shared types for the complementary-pair lock.
// Assumes nothing beyond being compiled before the modules that import it.
package cplock_pkg;
    // Selects which side of the complementary pair a branch evaluates
    typedef enum logic {
        BR_TRUE  = 1'b0,
        BR_COMPL = 1'b1
    } branch_e;
endpackage

// File: rtl/cplock_keymix.sv
// Per-bit key mixing stage: each input bit is combined with a key bit,
// using XNOR where INV_MASK is 1 and XOR elsewhere.
// Assumes x and k have the same width N.
module cplock_keymix #(
    parameter int          N        = 6,
    parameter logic [N-1:0] INV_MASK = '0
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] k,
    output logic [N-1:0] m
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (INV_MASK[i]) begin : g_xnor
            // XNOR key gate for this position
            assign m[i] = ~(x[i] ^ k[i]);
        end else begin : g_xor
            // XOR key gate for this position
            assign m[i] = x[i] ^ k[i];
        end
    end
endmodule

// File: rtl/cplock_gterm.sv
// One branch of the complementary pair: the N-input AND of the mixed
// vector, or its inverse when KIND selects the complement side.
// Assumes the caller supplies an already key-mixed vector.
module cplock_gterm
    import cplock_pkg::*;
#(
    parameter int      N    = 6,
    parameter branch_e KIND = BR_TRUE
) (
    input  logic [N-1:0] v,
    output logic         t
);
    if (KIND == BR_TRUE) begin : g_true
        // True side: high only when every mixed bit is high
        assign t = &v;
    end else begin : g_compl
        // Complement side: low only when every mixed bit is high
        assign t = ~(&v);
    end
endmodule

// File: rtl/cplock_demo_fn.sv
// Example protected function: bit j is the XOR of input bits j and j+1,
// wrapping at the top bit.
// Assumes N is at least 2.
module cplock_demo_fn #(
    parameter int N = 6
) (
    input  logic [N-1:0] x,
    output logic [N-1:0] y
);
    for (genvar j = 0; j < N; j++) begin : g_out
        // Neighbour XOR with wrap-around
        assign y[j] = x[j] ^ x[(j + 1) % N];
    end
endmodule

// File: rtl/cplock_top.sv
// Complementary-pair lock wrapped around the example function.
// A true branch and an inverted branch, each keyed by its own key half,
// are ANDed into a flip signal that is XORed into output bit PROT_IDX.
// Both output vectors are registered with a synchronous active-low reset.
// Assumes PROT_IDX < N and that prim_in and the keys are stable at the clock edge.
module cplock_top
    import cplock_pkg::*;
#(
    parameter int           N        = 6,
    parameter logic [N-1:0] POL      = 6'b101100,
    parameter int           PROT_IDX = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] prim_in,
    input  logic [N-1:0] key_a,
    input  logic [N-1:0] key_b,
    output logic [N-1:0] fn_out,
    output logic [N-1:0] locked_out
);
    localparam logic [N-1:0] NO_INV = '0;

    logic [N-1:0] mix_a;
    logic [N-1:0] mix_b;
    logic         br_a;
    logic         br_b;
    logic         flip;
    logic [N-1:0] fn_val;
    logic [N-1:0] lock_val;

    cplock_keymix #(.N(N), .INV_MASK(POL)) u_mix_a (
        .x(prim_in), .k(key_a), .m(mix_a)
    );

    cplock_keymix #(.N(N), .INV_MASK(NO_INV)) u_mix_b (
        .x(prim_in), .k(key_b), .m(mix_b)
    );

    cplock_gterm #(.N(N), .KIND(BR_TRUE)) u_br_a (
        .v(mix_a), .t(br_a)
    );

    cplock_gterm #(.N(N), .KIND(BR_COMPL)) u_br_b (
        .v(mix_b), .t(br_b)
    );

    cplock_demo_fn #(.N(N)) u_fn (
        .x(prim_in), .y(fn_val)
    );

    // Flip fires only when both sides of the pair are high
    assign flip = br_a & br_b;

    for (genvar j = 0; j < N; j++) begin : g_lock
        if (j == PROT_IDX) begin : g_prot
            // Inserted flip gate on the protected bit
            assign lock_val[j] = fn_val[j] ^ flip;
        end else begin : g_pass
            // Unprotected bit passes straight through
            assign lock_val[j] = fn_val[j];
        end
    end

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_out     <= '0;
            locked_out <= '0;
        end else begin
            fn_out     <= fn_val;
            locked_out <= lock_val;
        end
    end
endmodule

// File: rtl/cplock_checker.sv
// Port-level properties of the complementary-pair lock, bound to cplock_top.
// Assumes the same parameter values as the bound instance.
module cplock_checker #(
    parameter int           N        = 6,
    parameter logic [N-1:0] POL      = 6'b101100,
    parameter int           PROT_IDX = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] prim_in,
    input logic [N-1:0] key_a,
    input logic [N-1:0] key_b,
    input logic [N-1:0] fn_out,
    input logic [N-1:0] locked_out
);
    localparam logic [N-1:0] KEEP_MASK = ~({{(N-1){1'b0}}, 1'b1} << PROT_IDX);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (fn_out == '0 && locked_out == '0)); // R1

    AST_FN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> fn_out == $past(prim_in ^ {prim_in[0], prim_in[N-1:1]})); // R2

    AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((locked_out ^ fn_out) & KEEP_MASK) == '0); // R3

    AST_ONE_BIT_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(locked_out ^ fn_out)); // R3

    AST_GOOD_KEY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ((key_a ^ key_b) == POL) |=> (locked_out == fn_out)); // R4

    AST_FLIP_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((locked_out[PROT_IDX] ^ fn_out[PROT_IDX]) ==
                   $past((&(prim_in ^ key_a ^ POL)) && !(&(prim_in ^ key_b))))); // R5
endmodule

bind cplock_top cplock_checker #(.N(N), .POL(POL), .PROT_IDX(PROT_IDX)) u_cplock_checker (
    .clk(clk), .rst_n(rst_n), .prim_in(prim_in), .key_a(key_a), .key_b(key_b),
    .fn_out(fn_out), .locked_out(locked_out)
);

// File: tb/cplock_top_bench.sv
// Directed bench for cplock_top: one task per scenario, each self-checking.
module cplock_top_bench;
    localparam int           CLK_PERIOD = 10;
    localparam int           N          = 6;
    localparam logic [N-1:0] POL        = 6'b101100;
    localparam int           PROT_IDX   = 2;
    localparam int           NPAT       = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] prim_in = '0;
    logic [N-1:0] key_a = '0;
    logic [N-1:0] key_b = '0;
    logic [N-1:0] fn_out;
    logic [N-1:0] locked_out;

    int n_tests = 0;
    int n_fail  = 0;

    cplock_top #(.N(N), .POL(POL), .PROT_IDX(PROT_IDX)) u_cplock_top (
        .clk(clk), .rst_n(rst_n), .prim_in(prim_in), .key_a(key_a), .key_b(key_b),
        .fn_out(fn_out), .locked_out(locked_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected example function from R2
    function automatic logic [N-1:0] exp_fn(input logic [N-1:0] x);
        logic [N-1:0] r;
        for (int j = 0; j < N; j++) r[j] = x[j] ^ x[(j + 1) % N];
        return r;
    endfunction

    // Expected corruption condition from R5
    function automatic logic exp_flip(input logic [N-1:0] x, input logic [N-1:0] ka,
                                      input logic [N-1:0] kb);
        return (&(x ^ ka ^ POL)) && !(&(x ^ kb));
    endfunction

    task automatic check(input logic ok, input string req, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply one input at a falling edge, sample after the next rising edge
    task automatic apply(input logic [N-1:0] x);
        @(negedge clk);
        prim_in = x;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n   = 1'b0;
        prim_in = 6'b010111;
        key_a   = 6'h3F;
        key_b   = 6'h00;
        repeat (2) @(negedge clk);
        check(fn_out == '0, "R1", fn_out, '0);
        check(locked_out == '0, "R1", locked_out, '0);
        rst_n = 1'b1;
    endtask

    // Correct key pair, full sweep: function value and clean pass-through
    task automatic t_good_sweep(input logic [N-1:0] ka);
        key_a = ka;
        key_b = ka ^ POL;
        for (int p = 0; p < NPAT; p++) begin
            apply(N'(p));
            check(fn_out == exp_fn(N'(p)), "R2", fn_out, exp_fn(N'(p)));
            check(locked_out == fn_out, "R4", locked_out, fn_out);
        end
    endtask

    // Several distinct correct pairs must all be accepted
    task automatic t_many_good();
        int bad;
        logic [N-1:0] keys [4] = '{6'h00, 6'h15, 6'h2A, 6'h3F};
        foreach (keys[i]) begin
            bad = 0;
            key_a = keys[i];
            key_b = keys[i] ^ POL;
            for (int p = 0; p < NPAT; p++) begin
                apply(N'(p));
                if (locked_out != fn_out) bad++;
            end
            check(bad == 0, "R7", N'(bad), '0);
        end
    endtask

    // Wrong pair: exactly one corrupted pattern, at the predicted input
    task automatic t_wrong_key(input logic [N-1:0] ka, input logic [N-1:0] kb);
        int hits;
        logic [N-1:0] diff;
        logic [N-1:0] exp_diff;
        hits  = 0;
        key_a = ka;
        key_b = kb;
        for (int p = 0; p < NPAT; p++) begin
            apply(N'(p));
            diff     = locked_out ^ fn_out;
            exp_diff = '0;
            exp_diff[PROT_IDX] = exp_flip(N'(p), ka, kb);
            if (diff != '0) hits++;
            check(diff == exp_diff, "R5", diff, exp_diff);
            check((diff & ~(N'(1) << PROT_IDX)) == '0, "R3", diff, exp_diff);
            if (N'(p) == ~(ka ^ POL))
                check(diff[PROT_IDX] == 1'b1, "R6", diff, exp_diff);
        end
        check(hits == 1, "R6", N'(hits), N'(1));
    endtask

    initial begin
        t_reset();
        t_good_sweep(6'h09);
        t_many_good();
        t_wrong_key(6'h00, 6'h00);
        t_wrong_key(6'h3F, 6'h15);
        t_wrong_key(POL, POL);
        t_wrong_key(6'h01, 6'h01 ^ POL ^ 6'h01);
        t_wrong_key(6'h12, 6'h12 ^ POL ^ 6'h20);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule